// File: doc/BRIEF.md
# Pulse Insert/Delete Oscillator with Reloadable Divider

This block is the numerically controlled oscillator of an all-digital phase-locked loop. It runs from one fast local clock. It forms a steady stream of count pulses at half that clock rate. The loop filter can speed up or slow down this stream one pulse at a time. An advance command places one extra pulse in a free slot. A retard command removes one pulse that would otherwise have occurred. The adjusted stream drives a divide-by-N counter. The output signal changes level each time the counter wraps, so one half-period of the output spans N adjusted pulses.

The division ratio comes from a separate frequency measurement and can change while the block runs. This lets the centre frequency follow the input signal. A new ratio is taken only when the counter wraps, so an output half-period that has already started is never cut short. Ratios below two are raised to two. An advance or retard command that arrives while an earlier command of the same kind is still waiting for its slot is held in a second flag, so it is not lost.

Top module: `pid_nco`

## Requirements
- R1: While reset is asserted, `out_o` is 0. The divider ratio in use is the parameter `N_INIT`.
- R2: With no commands and a steady ratio N, `out_o` toggles every 2*N clock cycles. The base pulse stream has one pulse every second clock, so the output duty is 50%.
- R3: Each single-cycle pulse on `adv_i` inserts exactly one extra count pulse. The output half-period in which it is consumed becomes 2 clock cycles shorter.
- R4: Each single-cycle pulse on `ret_i` deletes exactly one base count pulse. The output half-period in which it is consumed becomes 2 clock cycles longer.
- R5: Two commands of the same kind on consecutive cycles both take effect. The half-period changes by 4 cycles.
- R6: An advance and a retard given in the same cycle cancel. The half-period stays at 2*N.
- R7: A value on `ratio_i` is loaded only at a divider wrap. The half-period that is running when the value changes keeps the old ratio, and the next half-period uses the new one.
- R8: A `ratio_i` value of 0 or 1 is used as 2. The half-period is then 4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local high-speed clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| adv_i | input | 1 | Advance command, one cycle per extra pulse |
| ret_i | input | 1 | Retard command, one cycle per deleted pulse |
| ratio_i | input | NW | Measured division ratio N |
| out_o | output | 1 | Recovered output signal |

## Verification
The bench measures the time between output edges. It compares each measurement with a value computed from N and from the numbers of advances and retards: 2*(N - advances + retards). The stimulus is a plain steady run, single advances and single retards, back-to-back pairs of the same kind, and advance and retard given together. Steady runs separate a correct base rate from an off-by-one in the divider. Single commands show whether one command moves exactly one pulse. Back-to-back pairs show whether the holding flag loses a command. Ratio changes given in the middle of a half-period, and values below two, show whether the reload waits for the wrap and whether the clamp works. Random ratios and command mixes from a fixed seed repeat these measurements.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int unsigned PID_NMIN = 2;

  function automatic logic [31:0] pid_clamp(input logic [31:0] n);
    pid_clamp = (n < PID_NMIN) ? PID_NMIN : n;
  endfunction
endpackage

// File: rtl/pid_rst_sync.sv
module pid_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/pid_cmd_flag.sv
module pid_cmd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic slot_i,
  output logic pend_o
);
  logic pend_q, hold_q;
  logic pend_d, hold_d;
  logic take;

  assign take = slot_i & pend_q;

  always_comb begin
    pend_d = pend_q;
    hold_d = hold_q;
    if (take) begin
      pend_d = hold_q | cmd_i;
      hold_d = hold_q & cmd_i;
    end else if (cmd_i) begin
      if (!pend_q) pend_d = 1'b1;
      else         hold_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      hold_q <= hold_d;
    end
  end

  assign pend_o = pend_q;

  // R5
  hold_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> pend_q);

  // R3
  take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hold_q && !cmd_i) |=> !pend_q);
endmodule

// File: rtl/pid_divider.sv
module pid_divider #(
  parameter int NW     = 16,
  parameter int N_INIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_i,
  input  logic [NW-1:0] ratio_i,
  output logic          out_o
);
  import pid_pkg::*;

  localparam logic [NW-1:0] NRST = NW'(pid_clamp(32'(N_INIT)));

  logic [NW-1:0] cnt_q, cnt_d;
  logic [NW-1:0] nuse_q, nuse_d;
  logic          out_q, out_d;
  logic          wrap;
  logic [31:0]   ratio_ext;

  assign ratio_ext = 32'(ratio_i);
  assign wrap      = pulse_i && (cnt_q == nuse_q - 1'b1);

  always_comb begin
    cnt_d  = cnt_q;
    nuse_d = nuse_q;
    out_d  = out_q;
    if (pulse_i) begin
      if (wrap) begin
        cnt_d  = '0;
        out_d  = ~out_q;
        nuse_d = NW'(pid_clamp(ratio_ext));
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      nuse_q <= NRST;
      out_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      nuse_q <= nuse_d;
      out_q  <= out_d;
    end
  end

  assign out_o = out_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < nuse_q);

  // R8
  ratio_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nuse_q >= NW'(PID_NMIN));

  // R7
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(nuse_q));

  // R2
  out_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_i |=> $stable(out_q));
endmodule

// File: rtl/pid_nco.sv
module pid_nco #(
  parameter int NW     = 16,
  parameter int N_INIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          ret_i,
  input  logic [NW-1:0] ratio_i,
  output logic          out_o
);
  logic rst_sync_n;
  logic ph_q, ph_d;
  logic adv_pend, ret_pend;
  logic pulse;

  pid_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ph_d = ~ph_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ph_q <= 1'b0;
    else             ph_q <= ph_d;
  end

  pid_cmd_flag u_adv (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd_i  (adv_i),
    .slot_i (~ph_q),
    .pend_o (adv_pend)
  );

  pid_cmd_flag u_ret (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd_i  (ret_i),
    .slot_i (ph_q),
    .pend_o (ret_pend)
  );

  always_comb begin
    if (ph_q) pulse = ~ret_pend;
    else      pulse = adv_pend;
  end

  pid_divider #(.NW(NW), .N_INIT(N_INIT)) u_div (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pulse_i (pulse),
    .ratio_i (ratio_i),
    .out_o   (out_o)
  );

  // R2
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ph_q |=> !ph_q);

  // R1
  reset_out_chk: assert property (@(posedge clk)
    !rst_sync_n |-> !out_o);
endmodule

// File: tb/sim_pid_nco.sv
module sim_pid_nco;
  localparam int NW = 16;

  logic          clk;
  logic          rst_n;
  logic          adv_i;
  logic          ret_i;
  logic [NW-1:0] ratio_i;
  logic          out_o;

  int checks;
  int fails;
  int cyc;
  bit timed_out;

  pid_nco #(.NW(NW), .N_INIT(8)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv_i),
    .ret_i   (ret_i),
    .ratio_i (ratio_i),
    .out_o   (out_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_half(input int n, input int a, input int r);
    int nn = (n < 2) ? 2 : n;
    return 2 * (nn - a + r);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tog(input int start, output int dt);
    logic prev = out_o;
    int g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (out_o == prev && g < 2000);
    if (g >= 2000) begin
      timed_out = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=toggle", g);
    end
    dt = cyc - start;
  endtask

  task automatic run_cmd(input int n, input int a, input int r,
                         input string req);
    int st, dt;
    st = cyc;
    for (int i = 0; i < 2; i++) begin
      adv_i = (i < a);
      ret_i = (i < r);
      @(negedge clk);
    end
    adv_i = 1'b0;
    ret_i = 1'b0;
    wait_tog(st - 0, dt);
    check(req, dt, exp_half(n, a, r));
  endtask

  task automatic set_ratio(input int n);
    int dt;
    ratio_i = NW'(n);
    wait_tog(cyc, dt);
    wait_tog(cyc, dt);
  endtask

  initial begin
    int dt;
    checks = 0;
    fails = 0;
    timed_out = 1'b0;
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    adv_i = 1'b0;
    ret_i = 1'b0;
    ratio_i = NW'(5);
    repeat (3) @(negedge clk);
    check("R1 out during reset", int'(out_o), 0);
    rst_n = 1'b1;

    // first wrap loads ratio 5, after that plain half-periods (R2, R7)
    wait_tog(cyc, dt);
    wait_tog(cyc, dt);
    check("R2 steady N=5", dt, 10);
    wait_tog(cyc, dt);
    check("R2 steady N=5 again", dt, 10);

    // R7: change mid half-period, old ratio finishes first
    ratio_i = NW'(9);
    wait_tog(cyc, dt);
    check("R7 old ratio kept", dt, 10);
    wait_tog(cyc, dt);
    check("R7 new ratio used", dt, 18);

    // R8: clamp
    ratio_i = NW'(1);
    wait_tog(cyc, dt);
    wait_tog(cyc, dt);
    check("R8 ratio 1 clamped", dt, 4);
    ratio_i = NW'(0);
    wait_tog(cyc, dt);
    wait_tog(cyc, dt);
    check("R8 ratio 0 clamped", dt, 4);

    // directed commands at N=8
    set_ratio(8);
    run_cmd(8, 1, 0, "R3 single advance");
    run_cmd(8, 0, 1, "R4 single retard");
    run_cmd(8, 2, 0, "R5 two advances");
    run_cmd(8, 0, 2, "R5 two retards");
    run_cmd(8, 1, 1, "R6 advance and retard cancel");
    wait_tog(cyc, dt);
    check("R2 steady after commands", dt, 16);

    // constrained random
    for (int k = 0; k < 40; k++) begin
      int n = 6 + int'($urandom % 15);
      int a = int'($urandom % 3);
      int r = int'($urandom % 3);
      string tag;
      if (a == r)     tag = "R6 random balanced";
      else if (a > r) tag = (a == 2) ? "R5 random advances" : "R3 random advance";
      else            tag = (r == 2) ? "R5 random retards" : "R4 random retard";
      set_ratio(n);
      run_cmd(n, a, r, tag);
      if (timed_out) break;
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #3000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule